// File: doc/BRIEF.md
# Output Fault Supervisor with Selectable Delays

This block decides, cycle by cycle, which of six power output switches may conduct. The switches come in three low-side/high-side pairs. The block reads digital fault flags that come from analog detectors elsewhere: one overcurrent flag per output, undervoltage and overvoltage flags for the load supply, and a thermal warning flag and a thermal shutdown flag for the die. It turns them into an enable mask and three sticky fault indications: short circuit, supply fault and thermal shutdown.

Each fault delay is counted in ticks of a slow timebase. In the target system this is a tick near 45 kHz, so the default tick counts give about 100 ms or 12.5 ms for a short and 14 ms or 3.5 ms for a supply fault. A control bit, `sct_i`, picks the long or the short delay set at run time. The fault types recover in different ways. Supply faults release the outputs as soon as the supply is back to normal. Short circuits and thermal shutdown hold the outputs off until a reset pulse arrives on `srr_i`. A thermal warning during an overcurrent makes the short-circuit shutdown immediate.

Mask bit 2k drives low-side switch k and bit 2k+1 drives high-side switch k. The block treats all six channels the same way.

Top module: `fsup_supervisor`

## Requirements
- R1: After reset, `en_o` is all ones and `scd_o`, `psf_o` and `tsd_o` are low.
- R2: When `oc_i[i]` stays high, `en_o[i]` goes low and `scd_o` goes high at the clock edge that completes SC_SHORT_TICKS ticks if `sct_i` is 0, or SC_LONG_TICKS ticks if `sct_i` is 1. The other mask bits are not affected.
- R3: When `oc_i[i]` and `tp_i` are both high, `en_o[i]` is low and `scd_o` is high after the next clock edge, with no tick needed.
- R4: A short-circuit shutdown stays in force after `oc_i[i]` falls. A one-cycle `srr_i` pulse sets the mask bit back to 1 and clears `scd_o`.
- R5: When `uv_i` or `ov_i` stays high, all mask bits go low and `psf_o` goes high at the edge that completes SUP_SHORT_TICKS ticks (`sct_i`=0) or SUP_LONG_TICKS ticks (`sct_i`=1).
- R6: One clock edge after both `uv_i` and `ov_i` are low, the supply shutdown is lifted. `psf_o` stays high until `srr_i`.
- R7: One edge after `tsd_i` is high, all mask bits are low and `tsd_o` is high. This holds until `srr_i` arrives while `tsd_i` is low; an `srr_i` while `tsd_i` is high has no effect.
- R8: A fault condition that goes away before its delay expires clears its timer. The next occurrence counts the full delay again.
- R9: The timers advance only on cycles with `tick_i` high. Without ticks, no delayed shutdown occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle timebase pulse |
| sct_i | input | 1 | Delay select: 1 = long delays, 0 = short delays |
| srr_i | input | 1 | Fault-latch reset pulse |
| oc_i | input | N_OUT | Per-output overcurrent flags |
| uv_i | input | 1 | Supply undervoltage flag |
| ov_i | input | 1 | Supply overvoltage flag |
| tp_i | input | 1 | Thermal warning flag |
| tsd_i | input | 1 | Thermal shutdown flag |
| en_o | output | N_OUT | Per-output enable mask |
| scd_o | output | 1 | Sticky short-circuit indication |
| psf_o | output | 1 | Sticky supply-fault indication |
| tsd_o | output | 1 | Thermal shutdown latch |

## Verification
The hardest cases to reach are the timer boundaries. A shutdown must not appear one tick early. A timer must restart after an interruption in the middle of a count, instead of carrying over its partial count. The bench uses small tick counts and holds `tick_i` high, so each delay equals a known number of edges. It then samples one edge before and exactly at expiry, and it breaks an overcurrent for a single cycle partway through a count. The thermal latch needs a reset pulse sent while the shutdown flag is still high, followed by one sent after the flag has cleared.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/fsup_delay_timer.sv
module fsup_delay_timer #(
    parameter int unsigned CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             active,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic at_end;

    always_comb begin
        tmr_d  = tmr_q;
        at_end = (tmr_q.cnt >= (limit - CNT_W'(1)));
        expire = active && !clr && tick && at_end;
        if (!active || clr) begin
            tmr_d.cnt = '0;
        end else if (tick && !at_end) begin
            tmr_d.cnt = tmr_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (tmr_q.cnt == '0));

    // R9
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !clr && !tick) |=> $stable(tmr_q.cnt));
endmodule

// File: rtl/fsup_supervisor.sv
module fsup_supervisor #(
    parameter int unsigned N_OUT           = 6,
    parameter int unsigned SC_LONG_TICKS   = 4500,
    parameter int unsigned SC_SHORT_TICKS  = 563,
    parameter int unsigned SUP_LONG_TICKS  = 630,
    parameter int unsigned SUP_SHORT_TICKS = 158
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             sct_i,
    input  logic             srr_i,
    input  logic [N_OUT-1:0] oc_i,
    input  logic             uv_i,
    input  logic             ov_i,
    input  logic             tp_i,
    input  logic             tsd_i,
    output logic [N_OUT-1:0] en_o,
    output logic             scd_o,
    output logic             psf_o,
    output logic             tsd_o
);
    import fsup_pkg::*;

    localparam int unsigned MAX_TICKS = max2(max2(SC_LONG_TICKS, SC_SHORT_TICKS),
                                             max2(SUP_LONG_TICKS, SUP_SHORT_TICKS));
    localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

    typedef struct packed {
        logic [N_OUT-1:0] short_off;
        logic             scd;
        logic             psf;
        logic             sup_off;
        logic             tsd;
    } sup_state_t;

    sup_state_t st_d, st_q;

    logic [CNT_W-1:0] sc_lim, sup_lim;
    logic [N_OUT-1:0] sc_exp;
    logic [N_OUT-1:0] trip;
    logic             sup_bad, sup_exp;

    assign sc_lim  = sct_i ? CNT_W'(SC_LONG_TICKS)  : CNT_W'(SC_SHORT_TICKS);
    assign sup_lim = sct_i ? CNT_W'(SUP_LONG_TICKS) : CNT_W'(SUP_SHORT_TICKS);
    assign sup_bad = uv_i | ov_i;

    for (genvar gi = 0; gi < N_OUT; gi++) begin : g_sc
        fsup_delay_timer #(.CNT_W(CNT_W)) u_sc_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick_i),
            .active (oc_i[gi]),
            .clr    (srr_i),
            .limit  (sc_lim),
            .expire (sc_exp[gi])
        );
    end

    fsup_delay_timer #(.CNT_W(CNT_W)) u_sup_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_i),
        .active (sup_bad),
        .clr    (1'b0),
        .limit  (sup_lim),
        .expire (sup_exp)
    );

    always_comb begin
        trip = sc_exp | (oc_i & {N_OUT{tp_i}});
        st_d = st_q;
        st_d.short_off = (srr_i ? '0 : st_q.short_off) | trip;
        st_d.scd       = (srr_i ? 1'b0 : st_q.scd) | (|trip);
        st_d.sup_off   = sup_bad & (st_q.sup_off | sup_exp);
        st_d.psf       = (srr_i ? 1'b0 : st_q.psf) | sup_exp;
        st_d.tsd       = tsd_i | (st_q.tsd & !srr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o  = ~st_q.short_off & {N_OUT{~st_q.sup_off & ~st_q.tsd}};
    assign scd_o = st_q.scd;
    assign psf_o = st_q.psf;
    assign tsd_o = st_q.tsd;

    // R3
    warn_fast_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(oc_i & {N_OUT{tp_i}})) |=> ((en_o & $past(oc_i)) == '0) && scd_o);

    // R7
    thermal_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tsd_i |=> (en_o == '0) && tsd_o);

    // R6
    supply_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_bad |=> !st_q.sup_off);

    // R6
    psf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psf_o && !srr_i) |=> psf_o);

    // R4
    scd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scd_o && !srr_i) |=> scd_o);
endmodule

// File: tb/tb_fsup_supervisor.sv
module tb_fsup_supervisor;
    localparam int unsigned N    = 6;
    localparam int unsigned SC_L = 40;
    localparam int unsigned SC_S = 10;
    localparam int unsigned SU_L = 12;
    localparam int unsigned SU_S = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_i = 1'b1, sct_i = 1'b0, srr_i = 1'b0;
    logic [N-1:0] oc_i = '0;
    logic uv_i = 1'b0, ov_i = 1'b0, tp_i = 1'b0, tsd_i = 1'b0;
    logic [N-1:0] en_o;
    logic scd_o, psf_o, tsd_o;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    fsup_supervisor #(
        .N_OUT(N), .SC_LONG_TICKS(SC_L), .SC_SHORT_TICKS(SC_S),
        .SUP_LONG_TICKS(SU_L), .SUP_SHORT_TICKS(SU_S)
    ) dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sct_i(sct_i), .srr_i(srr_i),
        .oc_i(oc_i), .uv_i(uv_i), .ov_i(ov_i), .tp_i(tp_i), .tsd_i(tsd_i),
        .en_o(en_o), .scd_o(scd_o), .psf_o(psf_o), .tsd_o(tsd_o)
    );

    typedef struct packed {
        logic [N-1:0] oc;
        logic         uv;
        logic         ov;
        logic         tp;
        logic         sct;
        logic [15:0]  cyc;
        logic [N-1:0] en;
        logic         scd;
        logic         psf;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{6'b000001, 1'b0, 1'b0, 1'b0, 1'b0, 16'd9,  6'h3F, 1'b0, 1'b0}, // R2 one early
        '{6'b000001, 1'b0, 1'b0, 1'b0, 1'b0, 16'd10, 6'h3E, 1'b1, 1'b0}, // R2 short delay
        '{6'b100000, 1'b0, 1'b0, 1'b0, 1'b1, 16'd39, 6'h3F, 1'b0, 1'b0}, // R2 one early
        '{6'b100000, 1'b0, 1'b0, 1'b0, 1'b1, 16'd40, 6'h1F, 1'b1, 1'b0}, // R2 long delay
        '{6'b000000, 1'b1, 1'b0, 1'b0, 1'b0, 16'd4,  6'h3F, 1'b0, 1'b0}, // R5 one early
        '{6'b000000, 1'b1, 1'b0, 1'b0, 1'b0, 16'd5,  6'h00, 1'b0, 1'b1}, // R5 uv short
        '{6'b000000, 1'b0, 1'b1, 1'b0, 1'b1, 16'd11, 6'h3F, 1'b0, 1'b0}, // R5 one early
        '{6'b000000, 1'b0, 1'b1, 1'b0, 1'b1, 16'd12, 6'h00, 1'b0, 1'b1}, // R5 ov long
        '{6'b000110, 1'b0, 1'b0, 1'b1, 1'b1, 16'd1,  6'h39, 1'b1, 1'b0}, // R3 warning
        '{6'b010000, 1'b0, 1'b0, 1'b1, 1'b0, 16'd1,  6'h2F, 1'b1, 1'b0}  // R3 warning
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clear_all();
        oc_i = '0; uv_i = 1'b0; ov_i = 1'b0; tp_i = 1'b0; tsd_i = 1'b0;
        tick_i = 1'b1; srr_i = 1'b1;
        step(1);
        srr_i = 1'b0;
        step(1);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #1000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        step(2);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        check("R1 en", en_o, 6'h3F);
        check("R1 flags", {scd_o, psf_o, tsd_o}, 3'b000);

        for (int v = 0; v < NV; v++) begin
            string tag;
            tag = VECS[v].tp ? "R3" : ((VECS[v].uv | VECS[v].ov) ? "R5" : "R2");
            oc_i = VECS[v].oc; uv_i = VECS[v].uv; ov_i = VECS[v].ov;
            tp_i = VECS[v].tp; sct_i = VECS[v].sct;
            step(int'(VECS[v].cyc));
            check($sformatf("%s vec%0d en", tag, v), en_o, VECS[v].en);
            check($sformatf("%s vec%0d scd", tag, v), scd_o, VECS[v].scd);
            check($sformatf("%s vec%0d psf", tag, v), psf_o, VECS[v].psf);
            clear_all();
        end

        // R6 supply recovery
        sct_i = 1'b0; uv_i = 1'b1;
        step(5);
        check("R6 down", en_o, 6'h00);
        uv_i = 1'b0;
        step(1);
        check("R6 release", en_o, 6'h3F);
        check("R6 psf held", psf_o, 1'b1);
        srr_i = 1'b1; step(1); srr_i = 1'b0;
        check("R6 psf cleared", psf_o, 1'b0);
        clear_all();

        // R7 thermal latch
        tsd_i = 1'b1;
        step(1);
        check("R7 off", en_o, 6'h00);
        check("R7 flag", tsd_o, 1'b1);
        srr_i = 1'b1; step(1); srr_i = 1'b0;
        check("R7 srr while hot", {en_o, tsd_o}, {6'h00, 1'b1});
        tsd_i = 1'b0;
        step(3);
        check("R7 needs srr", {en_o, tsd_o}, {6'h00, 1'b1});
        srr_i = 1'b1; step(1); srr_i = 1'b0;
        check("R7 released", {en_o, tsd_o}, {6'h3F, 1'b0});
        clear_all();

        // R8 timer restart
        sct_i = 1'b0; oc_i = 6'b000100;
        step(7);
        oc_i = '0;
        step(1);
        oc_i = 6'b000100;
        step(9);
        check("R8 restarted", en_o, 6'h3F);
        step(1);
        check("R8 expiry", en_o, 6'h3B);

        // R4 latch persists, srr releases
        oc_i = '0;
        step(5);
        check("R4 held", {en_o, scd_o}, {6'h3B, 1'b1});
        srr_i = 1'b1; step(1); srr_i = 1'b0;
        check("R4 released", {en_o, scd_o}, {6'h3F, 1'b0});
        clear_all();

        // R9 no ticks, no delayed trip
        tick_i = 1'b0; sct_i = 1'b0; oc_i = 6'h3F;
        step(50);
        check("R9 frozen", {en_o, scd_o}, {6'h3F, 1'b0});
        tick_i = 1'b1;
        step(10);
        check("R9 ticking", {en_o, scd_o}, {6'h00, 1'b1});
        clear_all();

        finish_run();
    end
endmodule